// File: doc/BRIEF.md
# Three-Wire Nibble Serial Slave

This block is the slave end of a three-wire host link built from a chip enable, a serial clock and one bidirectional data line. It connects the host to a bank of sixteen 4-bit registers. The enable, serial clock and data input are oversampled by a fast system clock, and the block finds serial clock edges in that clock domain. While the enable is high, the serial stream is cut into frames of eight serial clocks. Each frame holds one ignored bit, three control flags and a nibble. Depending on the flags, a frame loads the address register, writes the nibble into the bank, or starts a read. A read returns the addressed nibble on the data line during the next frame.

The bank is outside this block. It sees a registered address, a write-data bus with a one-cycle strobe, and a combinational read-data return. The data pin is split into an output value and an output enable so that a pad cell can drive it. Frames follow one another without gaps for as long as the enable stays high. Taking the enable low cancels whatever is in progress.

Top module: `nibble_serial_slave`

## Requirements
- R1: After reset, sio_oe and reg_we are 0 and reg_addr is 0.
- R2: Each frame is eight serial clock rising edges, and the data line is sampled on each rising edge. Bit 1 is ignored. Bits 2, 3 and 4 are the flags RW, AD and DT. Bits 5 to 8 are a nibble, sent MSB first.
- R3: A frame with AD=1 and DT=0 puts its nibble in reg_addr. No other frame changes reg_addr.
- R4: A frame with DT=1, RW=0 and AD=0 pulses reg_we for exactly one system clock, with its nibble on reg_wdata and the current reg_addr. No other frame pulses reg_we.
- R5: A frame with RW=1, AD=1 and DT=0 is a read. It loads the address and takes the bank nibble at that address as the read value.
- R6: After a read frame, sio_oe rises at the falling edge of clock 2 of the next frame. It falls at the falling edge of clock 1 of the frame after that.
- R7: The read nibble is driven MSB first. Bit 3 starts at the falling edge of clock 5, bit 2 at clock 6, bit 1 at clock 7 and bit 0 at clock 8 of the output frame.
- R8: The bits received during the output frame are not decoded. They cause no address load and no write.
- R9: With the enable held high, the frame that begins with the clock that releases the data line is decoded as a normal frame. This lets a read be followed directly by writes.
- R10: Enable low clears the bit position, releases sio_oe and cancels a partial frame or a pending read without writing. reg_addr keeps its value.
- R11: A frame with all three flags at 0 has no effect.
- R12: Serial clock edges while the enable is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable from host, asynchronous |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| sio_i | input | 1 | Data line input from pad |
| sio_o | output | 1 | Data line output value to pad |
| sio_oe | output | 1 | Data line output enable to pad |
| reg_addr | output | 4 | Register bank address |
| reg_wdata | output | 4 | Register bank write data |
| reg_we | output | 1 | One-cycle register bank write strobe |
| reg_rdata | input | 4 | Combinational read data for reg_addr |

## Verification
The bench builds the block with its defaults: 4-bit nibbles, which give sixteen addresses, and two synchronizer stages. With these, every address is written and then read back serially. Each read also checks the enable window and the bit-by-bit output order. All eight flag combinations are swept with the ignored bit at both values. The remaining runs cover cancellation by the enable in the middle of a frame and during output, and serial clock activity while the enable is low.

// File: rtl/nss_pkg.sv
package nss_pkg;

  localparam int CTRL_BITS = 4;
  localparam int OE_ON_CLK = 2;
  localparam int OE_OFF_CLK = 1;

  typedef enum logic [1:0] {
    DRV_IDLE,
    DRV_ARMED,
    DRV_ACTIVE
  } drv_state_e;

  function automatic logic is_addr_load(logic rw, logic ad, logic dt);
    is_addr_load = ad & ~dt & (rw | ~rw);
  endfunction

  function automatic logic is_data_write(logic rw, logic ad, logic dt);
    is_data_write = dt & ~rw & ~ad;
  endfunction

  function automatic logic is_read(logic rw, logic ad, logic dt);
    is_read = rw & ad & ~dt;
  endfunction

  // Nibble bit index driven after the falling edge seen with count c;
  // -1 when that falling edge carries no data bit.
  function automatic int out_pos(int c, int ctrl_bits, int nib_w);
    if (c == 0) out_pos = 0;
    else if (c > ctrl_bits && c < ctrl_bits + nib_w)
      out_pos = nib_w - 1 - (c - ctrl_bits - 1);
    else out_pos = -1;
  endfunction

endpackage

// File: rtl/nss_sync.sv
module nss_sync #(
  parameter int N = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/nss_frame.sv
module nss_frame
  import nss_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int FRAME_LEN = CTRL_BITS + NIB_W,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_act,
  input  logic             sclk_lvl,
  input  logic             sio_lvl,
  input  logic             rd_busy,
  output logic             sclk_fall,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             frame_done,
  output logic             addr_load,
  output logic             rd_start,
  output logic [NIB_W-1:0] reg_addr,
  output logic [NIB_W-1:0] reg_wdata,
  output logic             reg_we
);

  logic                 sclk_q;
  logic                 sclk_rise;
  logic [FRAME_LEN-3:0] shreg;
  logic [FRAME_LEN-2:0] full;
  logic                 f_rw, f_ad, f_dt;
  logic [NIB_W-1:0]     f_nib;
  logic                 decode_en;
  logic                 wr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_lvl;
  end

  assign sclk_rise = ce_act & sclk_lvl & ~sclk_q;
  assign sclk_fall = ce_act & ~sclk_lvl & sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!ce_act) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (sclk_rise) begin
      shreg   <= {shreg[FRAME_LEN-4:0], sio_lvl};
      bit_cnt <= (bit_cnt == CNT_W'(FRAME_LEN - 1)) ? '0 : bit_cnt + 1'b1;
    end
  end

  assign frame_done = sclk_rise && (bit_cnt == CNT_W'(FRAME_LEN - 1));
  assign full  = {shreg, sio_lvl};
  assign f_rw  = full[FRAME_LEN-2];
  assign f_ad  = full[FRAME_LEN-3];
  assign f_dt  = full[FRAME_LEN-4];
  assign f_nib = full[NIB_W-1:0];

  assign decode_en = frame_done & ~rd_busy;
  assign addr_load = decode_en & is_addr_load(f_rw, f_ad, f_dt);
  assign wr_go     = decode_en & is_data_write(f_rw, f_ad, f_dt);
  assign rd_start  = decode_en & is_read(f_rw, f_ad, f_dt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_addr <= '0;
    else if (addr_load) reg_addr <= f_nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= wr_go;
      if (wr_go) reg_wdata <= f_nib;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_load |=> $stable(reg_addr)); // R3

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R4

  AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_act |=> !reg_we); // R10

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_act |=> (bit_cnt == '0)); // R10

  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> !wr_go); // R8

endmodule

// File: rtl/nss_sio_drv.sv
module nss_sio_drv
  import nss_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int FRAME_LEN = CTRL_BITS + NIB_W,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_act,
  input  logic             sclk_fall,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             rd_start,
  input  logic [NIB_W-1:0] reg_rdata,
  output logic             rd_busy,
  output logic             sio_o,
  output logic             sio_oe
);

  drv_state_e       state;
  logic             cap_pend;
  logic [NIB_W-1:0] rd_nib;
  logic             oe_on_ev;
  logic             oe_off_ev;
  logic             bit_ev;
  logic             next_bit;
  int               pos;

  assign oe_on_ev  = sclk_fall && state == DRV_ARMED  && bit_cnt == CNT_W'(OE_ON_CLK);
  assign oe_off_ev = sclk_fall && state == DRV_ACTIVE && bit_cnt == CNT_W'(OE_OFF_CLK);

  always_comb begin
    pos = out_pos(int'(bit_cnt), CTRL_BITS, NIB_W);
    next_bit = 1'b0;
    for (int k = 0; k < NIB_W; k++)
      if (pos == k) next_bit = rd_nib[k];
  end

  assign bit_ev  = sclk_fall && state == DRV_ACTIVE && pos >= 0;
  assign rd_busy = (state != DRV_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= DRV_IDLE;
      cap_pend <= 1'b0;
      rd_nib   <= '0;
      sio_oe   <= 1'b0;
      sio_o    <= 1'b0;
    end else if (!ce_act) begin
      state    <= DRV_IDLE;
      cap_pend <= 1'b0;
      sio_oe   <= 1'b0;
      sio_o    <= 1'b0;
    end else begin
      cap_pend <= rd_start;
      if (cap_pend) rd_nib <= reg_rdata;
      if (rd_start) state <= DRV_ARMED;
      if (oe_on_ev) begin
        state  <= DRV_ACTIVE;
        sio_oe <= 1'b1;
        sio_o  <= 1'b0;
      end else if (oe_off_ev) begin
        state  <= DRV_IDLE;
        sio_oe <= 1'b0;
        sio_o  <= 1'b0;
      end else if (bit_ev) begin
        sio_o <= next_bit;
      end
    end
  end

  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_act |=> !sio_oe); // R10

  AST_OE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sio_oe) |-> $past(sclk_fall)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe && $past(sio_oe) && !$past(sclk_fall)) |-> $stable(sio_o)); // R7

endmodule

// File: rtl/nibble_serial_slave.sv
module nibble_serial_slave
  import nss_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_LEN = CTRL_BITS + NIB_W,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic             sclk_i,
  input  logic             sio_i,
  output logic             sio_o,
  output logic             sio_oe,
  output logic [NIB_W-1:0] reg_addr,
  output logic [NIB_W-1:0] reg_wdata,
  output logic             reg_we,
  input  logic [NIB_W-1:0] reg_rdata
);

  logic [2:0]       sync_q;
  logic             ce_act, sclk_lvl, sio_lvl;
  logic             sclk_fall, frame_done, addr_load, rd_start, rd_busy;
  logic [CNT_W-1:0] bit_cnt;

  nss_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ce_i, sclk_i, sio_i}),
    .q    (sync_q)
  );

  assign {ce_act, sclk_lvl, sio_lvl} = sync_q;

  nss_frame #(.NIB_W(NIB_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_act    (ce_act),
    .sclk_lvl  (sclk_lvl),
    .sio_lvl   (sio_lvl),
    .rd_busy   (rd_busy),
    .sclk_fall (sclk_fall),
    .bit_cnt   (bit_cnt),
    .frame_done(frame_done),
    .addr_load (addr_load),
    .rd_start  (rd_start),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we)
  );

  nss_sio_drv #(.NIB_W(NIB_W)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_act   (ce_act),
    .sclk_fall(sclk_fall),
    .bit_cnt  (bit_cnt),
    .rd_start (rd_start),
    .reg_rdata(reg_rdata),
    .rd_busy  (rd_busy),
    .sio_o    (sio_o),
    .sio_oe   (sio_oe)
  );

  AST_READ_IS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> addr_load); // R5

  AST_DONE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ce_act); // R12

endmodule

// File: tb/nibble_serial_slave_test.sv
module nibble_serial_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_i = 1'b0, sclk_i = 1'b0, sio_i = 1'b0;
  logic       sio_o, sio_oe, reg_we;
  logic [3:0] reg_addr, reg_wdata, reg_rdata;

  logic [3:0] bank [16];
  logic [3:0] exp_bank [16];
  int         we_cnt = 0;
  int         checks = 0, errors = 0;
  logic [7:0] oe_seen, so_seen;
  logic       tail_oe, tail_so;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_serial_slave uut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .sclk_i(sclk_i), .sio_i(sio_i),
    .sio_o(sio_o), .sio_oe(sio_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = bank[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) bank[k] <= 4'(k ^ 5);
    end else if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  function automatic logic [3:0] pat(int a);
    return 4'((a * 7 + 3) % 16);
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int k = 0; k < n; k++) begin
      sclk_i = 1'b0;
      sio_i  = b[7-k];
      wait_cyc(HALF);
      oe_seen[7-k] = sio_oe;
      so_seen[7-k] = sio_o;
      sclk_i = 1'b1;
      wait_cyc(HALF);
    end
  endtask

  task automatic send_frame(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic tail();
    sclk_i = 1'b0;
    wait_cyc(HALF);
    tail_oe = sio_oe;
    tail_so = sio_o;
  endtask

  task automatic ce_up();
    sclk_i = 1'b0;
    ce_i = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic ce_down();
    sclk_i = 1'b0;
    wait_cyc(HALF);
    ce_i = 1'b0;
    wait_cyc(HALF);
  endtask

  function automatic logic [7:0] fr(logic ign, logic [2:0] ctl, logic [3:0] nib);
    return {ign, ctl, nib};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0;
    logic [3:0] v;
    for (int k = 0; k < 16; k++) exp_bank[k] = 4'(k ^ 5);
    wait_cyc(5);
    chk("R1 oe", 32'(sio_oe), 0);
    chk("R1 we", 32'(reg_we), 0);
    chk("R1 addr", 32'(reg_addr), 0);
    rst_n = 1'b1;
    wait_cyc(3);

    // R2 R3 R4: sweep every address with writes, ignored bit toggling
    ce_up();
    for (int a = 0; a < 16; a++) begin
      w0 = we_cnt;
      send_frame(fr(a[0], 3'b010, 4'(a)));
      chk("R3 addr load", 32'(reg_addr), 32'(a));
      send_frame(fr(~a[0], 3'b001, pat(a)));
      exp_bank[a] = pat(a);
      chk("R4 bank write", 32'(bank[a]), 32'(pat(a)));
      chk("R4 one strobe", 32'(we_cnt - w0), 1);
      chk("R2 addr kept", 32'(reg_addr), 32'(a));
    end
    ce_down();

    // R5 R6 R7 R8 R9: read each address, junk write frame during output
    ce_up();
    for (int a = 0; a < 16; a++) begin
      w0 = we_cnt;
      send_frame(fr(a[1], 3'b110, 4'(a)));
      chk("R5 read addr", 32'(reg_addr), 32'(a));
      send_frame(fr(1'b1, 3'b001, 4'hF));
      tail();
      chk("R6 oe window", 32'(oe_seen), 32'h3F);
      v = pat(a);
      chk("R7 bit3", 32'(so_seen[2]), 32'(v[3]));
      chk("R7 bit2", 32'(so_seen[1]), 32'(v[2]));
      chk("R7 bit1", 32'(so_seen[0]), 32'(v[1]));
      chk("R7 bit0", 32'({tail_oe, tail_so}), 32'({1'b1, v[0]}));
      chk("R8 no write", 32'(we_cnt - w0), 0);
      send_frame(fr(1'b0, 3'b010, 4'(15 - a)));
      chk("R6 release", 32'(oe_seen[7:6]), 32'h2);
      chk("R9 next frame", 32'(reg_addr), 32'(15 - a));
    end
    ce_down();

    // R3 R4 R11: all flag combinations except read
    ce_up();
    for (int c = 0; c < 8; c++) begin
      if (c == 6) continue;
      for (int ig = 0; ig < 2; ig++) begin
        send_frame(fr(1'b0, 3'b010, 4'd5));
        w0 = we_cnt;
        send_frame(fr(1'(ig), 3'(c), 4'(9 + c)));
        if (c[1] && !c[0]) begin
          chk("R3 load combo", 32'(reg_addr), 32'(9 + c));
        end else begin
          chk("R3 hold combo", 32'(reg_addr), 5);
        end
        if (c == 1) begin
          exp_bank[5] = 4'(9 + c);
          chk("R4 write combo", 32'(we_cnt - w0), 1);
        end else if (c == 0) begin
          chk("R11 null frame", 32'(we_cnt - w0), 0);
        end else begin
          chk("R4 no write combo", 32'(we_cnt - w0), 0);
        end
      end
    end
    ce_down();

    // R10: partial write frame aborted by enable low
    ce_up();
    send_frame(fr(1'b0, 3'b010, 4'd3));
    w0 = we_cnt;
    send_bits(fr(1'b0, 3'b001, 4'hA), 6);
    ce_down();
    chk("R10 no partial write", 32'(we_cnt - w0), 0);
    chk("R10 addr kept", 32'(reg_addr), 3);
    ce_up();
    send_frame(fr(1'b0, 3'b001, 4'h6));
    exp_bank[3] = 4'h6;
    chk("R10 clean restart", 32'(bank[3]), 6);
    ce_down();

    // R10: enable low while driving
    ce_up();
    send_frame(fr(1'b0, 3'b110, 4'd7));
    send_bits(fr(1'b0, 3'b000, 4'h0), 4);
    chk("R10 oe before abort", 32'(oe_seen[5]), 1);
    ce_down();
    chk("R10 oe released", 32'(sio_oe), 0);
    ce_up();
    w0 = we_cnt;
    send_frame(fr(1'b0, 3'b001, 4'hC));
    exp_bank[7] = 4'hC;
    chk("R10 decode after read abort", 32'(we_cnt - w0), 1);
    chk("R10 oe idle", 32'(oe_seen), 0);
    ce_down();

    // R12: serial clocks while enable low
    w0 = we_cnt;
    send_frame(fr(1'b0, 3'b010, 4'hE));
    send_frame(fr(1'b0, 3'b001, 4'h1));
    chk("R12 addr untouched", 32'(reg_addr), 7);
    chk("R12 no write", 32'(we_cnt - w0), 0);
    chk("R12 oe idle", 32'(sio_oe), 0);

    for (int a = 0; a < 16; a++)
      chk("R8 R11 bank image", 32'(bank[a]), 32'(exp_bank[a]));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule